// File: doc/BRIEF.md
# Chained Priority Encoder, 16 Lines

This block turns a bank of active-low request lines into the binary number of the most important request. Line 15 outranks line 14, and so on down to line 0. It is built from identical 8-line cells. Each cell has its own active-low enable input, group-valid output and pass-through enable output. The cells are chained so that a cell that sees a request cuts off every cell below it.

The block is purely combinational. The address, the group-valid flag and the pass-through enable are all active-low, so an idle bank reads as all ones.

The chain's own enable input and pass-through output are brought to the top. This lets a wider encoder be built by placing several of these blocks in a row, where each block's pass-through output feeds the enable input of the block below it.

Top module: `prienc_cascade`

## Requirements
- R1: With `en_in_n` high, `addr_n` is all ones and both `grp_n` and `en_out_n` are high, whatever the request lines hold.
- R2: With `en_in_n` low and every line of `in_n` high, `addr_n` is 4'b1111, `grp_n` is high and `en_out_n` is low.
- R3: With `en_in_n` low and line k the highest-numbered low line of `in_n`, `addr_n` equals the bitwise inverse of k as four bits, `grp_n` is low and `en_out_n` is high. For example, line 15 gives 4'b0000 and line 0 gives 4'b1111.
- R4: Once a higher-numbered line is low, the state of every lower-numbered line has no effect on any output.
- R5: A request in lines 15..8 disables the lower cell through the chain. When lines 15..8 are all high, a low line k in 7..0 still yields `addr_n` equal to the inverse of k, with bit 3 high.
- R6: `grp_n` and `en_out_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_n | input | 16 | Request lines, active-low; bit 15 has the highest rank |
| en_in_n | input | 1 | Block enable, active-low |
| addr_n | output | 4 | Number of the winning line, active-low (inverted binary) |
| grp_n | output | 1 | Low when an enabled request is present |
| en_out_n | output | 1 | Low when enabled and no request is present; drives the enable of a lower-ranked block |

## Verification
Each 8-bit pattern is swept over the lower byte while the upper byte is idle. This proves that the lower cell encodes on its own and that its result passes up the chain with bit 3 high.

The same sweep is repeated over the upper byte while the lower byte carries random noise. This shows that lower lines are ignored once an upper line wins.

Both sweeps run with the enable asserted and with it deasserted, which separates enable gating from encoding. Random 16-bit patterns then mix single and multiple requests across both cells, and the idle pattern tells the empty-bank case apart from line 0.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

    // Status pair reported by one encoder cell, both active-low.
    typedef struct packed {
        logic grp_n;   // low: this cell holds the winning request
        logic eo_n;    // low: enabled and empty, lower cells may answer
    } prienc_flags_t;

    localparam prienc_flags_t FLAGS_OFF   = '{grp_n: 1'b1, eo_n: 1'b1};
    localparam prienc_flags_t FLAGS_EMPTY = '{grp_n: 1'b1, eo_n: 1'b0};
    localparam prienc_flags_t FLAGS_HIT   = '{grp_n: 1'b0, eo_n: 1'b1};

endpackage

// File: rtl/prienc_scan.sv
module prienc_scan #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]         req,
    output logic [$clog2(WIDTH)-1:0] idx,
    output logic                     hit
);

    localparam int IW = $clog2(WIDTH);

    // Ascending scan: the last set bit seen is the highest-ranked one.
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (req[i]) begin
                idx = IW'(i);
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prienc_cell.sv
module prienc_cell
    import prienc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]         in_n,
    input  logic                     en_n,
    output logic [$clog2(WIDTH)-1:0] addr_n,
    output prienc_flags_t            flags
);

    localparam int IW = $clog2(WIDTH);

    logic [WIDTH-1:0] req;
    logic [IW-1:0]    idx;
    logic             hit;

    assign req = ~in_n;

    prienc_scan #(.WIDTH(WIDTH)) u_scan (
        .req (req),
        .idx (idx),
        .hit (hit)
    );

    always_comb begin
        if (en_n) begin
            addr_n = '1;
            flags  = FLAGS_OFF;
        end else if (hit) begin
            addr_n = ~idx;
            flags  = FLAGS_HIT;
        end else begin
            addr_n = '1;
            flags  = FLAGS_EMPTY;
        end
    end

    // The scan result must name a set line with nothing set above it.
    always_comb begin
        if (hit) begin
            assert_scan_top_R4: assert (req[idx] && ((req >> idx) == WIDTH'(1)));
        end
        assert_scan_hit_R3: assert (hit == (req != '0));
        assert_flags_excl_R6: assert (flags.grp_n || flags.eo_n);
    end

endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade
    import prienc_pkg::*;
#(
    parameter int CELL_W = 8,
    parameter int CELLS  = 2
) (
    input  logic [CELL_W*CELLS-1:0]         in_n,
    input  logic                            en_in_n,
    output logic [$clog2(CELL_W*CELLS)-1:0] addr_n,
    output logic                            grp_n,
    output logic                            en_out_n
);

    localparam int LW = $clog2(CELL_W);
    localparam int CW = $clog2(CELLS);

    logic          en_chain   [CELLS+1];
    logic [LW-1:0] cell_addr  [CELLS];
    prienc_flags_t cell_flags [CELLS];
    logic [CELLS-1:0] cell_act;

    assign en_chain[CELLS] = en_in_n;

    // Highest cell takes the block enable; each cell passes its empty flag down.
    generate
        for (genvar g = 0; g < CELLS; g++) begin : g_cell
            prienc_cell #(.WIDTH(CELL_W)) u_cell (
                .in_n   (in_n[g*CELL_W +: CELL_W]),
                .en_n   (en_chain[g+1]),
                .addr_n (cell_addr[g]),
                .flags  (cell_flags[g])
            );
            assign en_chain[g] = cell_flags[g].eo_n;
            assign cell_act[g] = ~cell_flags[g].grp_n;
        end
    endgenerate

    logic [LW-1:0] low_n;
    logic [CW-1:0] high_n;
    logic          grp_all_n;

    // Idle cells report all ones, so ANDing keeps only the winner's bits.
    always_comb begin
        low_n     = '1;
        high_n    = '1;
        grp_all_n = 1'b1;
        for (int c = 0; c < CELLS; c++) begin
            low_n     = low_n & cell_addr[c];
            grp_all_n = grp_all_n & cell_flags[c].grp_n;
            if (!cell_flags[c].grp_n) begin
                high_n = ~CW'(c);
            end
        end
    end

    assign addr_n   = {high_n, low_n};
    assign grp_n    = grp_all_n;
    assign en_out_n = en_chain[0];

    always_comb begin
        assert_one_cell_R5: assert ($onehot0(cell_act));
        assert_grp_valid_R3: assert (grp_n == (en_in_n || (&in_n)));
        assert_off_quiet_R1: assert (!en_in_n || (grp_n && en_out_n && (&addr_n)));
        assert_empty_pass_R2: assert (en_out_n == (en_in_n || !(&in_n)));
    end

endmodule

// File: tb/prienc_cascade_bench.sv
module prienc_cascade_bench;

    logic        clk = 1'b0;
    logic [15:0] in_n = '1;
    logic        en_in_n = 1'b1;
    logic [3:0]  addr_n;
    logic        grp_n;
    logic        en_out_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    prienc_cascade u_prienc_cascade (
        .in_n     (in_n),
        .en_in_n  (en_in_n),
        .addr_n   (addr_n),
        .grp_n    (grp_n),
        .en_out_n (en_out_n)
    );

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s in_n=%h en_n=%b got {addr,grp,eo}=%b expected %b",
                     req, in_n, en_in_n, got, exp);
        end
    endtask

    // Drive after the rising edge, compare at the falling edge.
    task automatic apply(input logic [15:0] v, input logic en);
        int top;
        logic [5:0] exp;
        string tag;
        int lows;
        @(posedge clk);
        #1;
        in_n    = v;
        en_in_n = en;
        top = -1;
        lows = 0;
        for (int i = 0; i < 16; i++) begin
            if (!v[i]) begin
                top = i;
                lows++;
            end
        end
        if (en) begin
            exp = 6'b111111; tag = "R1";
        end else if (top < 0) begin
            exp = 6'b111110; tag = "R2";
        end else begin
            exp = {~4'(top), 1'b0, 1'b1};
            if (top < 8)       tag = "R5";
            else if (lows > 1) tag = "R4";
            else               tag = "R3";
        end
        @(negedge clk);
        check(tag, {addr_n, grp_n, en_out_n}, exp);
        n_tests++;
        if (!grp_n && !en_out_n) begin
            n_fail++;
            $display("FAIL R6 grp_n=%b en_out_n=%b expected not both low", grp_n, en_out_n);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: disabled and idle (R1)
        @(negedge clk);
        check("R1", {addr_n, grp_n, en_out_n}, 6'b111111);
        // Explicit corners
        apply(16'hFFFF, 1'b0);   // R2 empty
        apply(16'h7FFF, 1'b0);   // R3 line 15 -> 0000
        apply(16'hFFFE, 1'b0);   // R5 line 0 -> 1111
        apply(16'h0000, 1'b0);   // R4 all low -> line 15
        apply(16'h0000, 1'b1);   // R1 disabled with all requests
        apply(16'hFEFF, 1'b0);   // R5 line 8 -> 0111, low cell blocked
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 256; p++) begin
                apply({8'hFF, 8'(p)}, 1'(e));
                apply({8'(p), 8'($urandom)}, 1'(e));
            end
        end
        for (int r = 0; r < 2000; r++) begin
            apply(16'($urandom), 1'($urandom % 8 == 0));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule